// File: doc/BRIEF.md
# I2C register transfer sequencer

This block turns one command (read, write or probe of a register inside an I2C slave) into the sequence of control writes, status polls and byte moves that a byte-level I2C controller needs. The command gives a 7-bit slave address, a register offset of zero, one or two bytes, a data length and a per-command choice between repeated start and stop-then-start before read data. The bit-level bus engine is outside the block. It is seen only through a status-flag vector, a bus-busy level, a received-byte input and pulses that launch transfers, push transmit bytes, pop received bytes and clear flags.

Write data is pulled from a local buffer one byte per `buf_rd` pulse, and read data is pushed to it with `buf_wr`. When the command ends, a one-cycle `cmd_done` carries a result code: 0 for success, 1 for a rejected command, NACK, timeout or failed probe, and 2 when the bus looks unconfigured. Status flag positions are: bit0 transmit ready, bit1 receive ready, bit2 access ready, bit3 NACK, bit4 arbitration lost, bit5 receive overrun, bit6 transmit underrun. Command opcodes are 0 read, 1 write, 2 probe, and 3 is invalid.

Top module: `i2c_reg_xfer_seq`

## Requirements
- R1: A command with opcode 3, an offset length above 2, or offset plus data length above 65536 ends on the next cycle with result 1 and no transfer launched.
- R2: Before any transfer the block waits for `ctl_busy` low; if the bus stays busy for POLL_MAX cycles the command ends with result 1 and no transfer launched.
- R3: Offset bytes go out high byte first, one per transmit-ready event, and each handled flag is cleared by a `ctl_stat_clr` pulse in the cycle it is handled.
- R4: A read with a nonzero offset length launches an offset transfer (count = offset length, start, transmit direction, stop only when `cmd_rstart` is 0), then a data transfer (count = data length, start, stop, receive direction); with no offset only the data transfer is launched.
- R5: In the read data phase each receive-ready event moves `ctl_rxd` to the buffer; access ready ends the read with result 0.
- R6: A write launches one transfer with count = offset length + data length, start, stop and transmit direction; data bytes follow the offset bytes and success (result 0) needs access ready after the last byte.
- R7: A status of transmit ready alone with `ctl_busy` low, seen in a read phase or the write offset phase, ends the command with result 2.
- R8: A NACK, or POLL_MAX cycles without any status flag, ends the command with result 1; a poll timeout clears all flags.
- R9: A probe of `own_addr` ends with result 1 and no transfer; otherwise an address-only transfer (count 0, start, stop, transmit) is launched; NACK, arbitration lost, a lone transmit ready or a timeout give result 1, while any other event gives a `ctl_abort` pulse, a stop-only launch and result 0.
- R10: Every command that launched a transfer pops pending received bytes without writing them to the buffer, then clears all flags in the cycle `cmd_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command presented (taken when `cmd_ready`) |
| cmd_op | input | 2 | 0 read, 1 write, 2 probe |
| cmd_addr | input | ADDR_W | Slave address |
| cmd_off | input | 16 | Register offset |
| cmd_olen | input | 2 | Offset length in bytes |
| cmd_len | input | LEN_W | Data length in bytes |
| cmd_rstart | input | 1 | 1: repeated start before read data |
| own_addr | input | ADDR_W | Controller's own slave address |
| cmd_ready | output | 1 | Sequencer idle |
| cmd_done | output | 1 | One-cycle end-of-command pulse |
| cmd_res | output | 2 | Result code, valid with `cmd_done` |
| ctl_busy | input | 1 | Bus busy level from the controller |
| ctl_stat | input | 7 | Controller status flags |
| ctl_rxd | input | 8 | Head of the receive queue |
| ctl_go | output | 1 | Launch pulse |
| ctl_stt | output | 1 | Start condition with launch |
| ctl_stp | output | 1 | Stop condition with launch |
| ctl_trx | output | 1 | Transmit direction with launch |
| ctl_cnt | output | LEN_W | Byte count with launch |
| ctl_sa | output | ADDR_W | Slave address for the transfer |
| ctl_abort | output | 1 | Force the controller idle |
| ctl_stat_clr | output | 7 | Write-one-to-clear flag pulses |
| ctl_tx_wr | output | 1 | Push `ctl_txd` |
| ctl_txd | output | 8 | Transmit byte |
| ctl_rx_rd | output | 1 | Pop the receive queue |
| buf_rd | output | 1 | Take the next write byte |
| buf_rdata | input | 8 | Current write byte |
| buf_wr | output | 1 | Store a received byte |
| buf_wdata | output | 8 | Received byte |

## Verification
The assertions assume a controller that raises transmit ready before a byte is pushed and receive ready before a byte is popped, and that clears flags on the edge after a clear pulse. The bench's controller model only raises flags in reaction to launches, pushes and pops, a few cycles later, so it never offers a byte the sequencer did not ask for. Random read and write commands keep offset length within 0 to 2 and data length small, while rejected commands, stuck busy, silent buses, lone transmit ready and mid-read NACK are injected as directed cases.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int NFLAG  = 7;
  localparam int F_XRDY = 0;
  localparam int F_RRDY = 1;
  localparam int F_ARDY = 2;
  localparam int F_NACK = 3;
  localparam int F_AL   = 4;

  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_PRB = 2'd2;

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_ERR  = 2'd1;
  localparam logic [1:0] RES_PADS = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_FAST, S_BB, S_ROFF, S_RDAT, S_WOFF, S_WDAT, S_WEND,
    S_PWAIT, S_ABT, S_STOP, S_DRAIN, S_FIN
  } seq_st_e;
endpackage

// File: rtl/i2cseq_waiter.sv
module i2cseq_waiter #(
  parameter int POLL_MAX = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic hit,
  output logic fire,
  output logic tmo
);
  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign tmo  = arm && !hit && (cnt_q == CW'(POLL_MAX - 1));
  assign fire = arm && (hit || tmo);

  always_comb begin
    cnt_n = cnt_q;
    if (!arm || fire) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R8: the poll window never runs past its limit
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(POLL_MAX));
endmodule

// File: rtl/i2cseq_cmd_chk.sv
module i2cseq_cmd_chk #(
  parameter int LEN_W = 17
) (
  input  logic [1:0]       op,
  input  logic [1:0]       olen,
  input  logic [15:0]      off,
  input  logic [LEN_W-1:0] len,
  output logic             bad
);
  localparam int SUM_W = (LEN_W > 16 ? LEN_W : 17) + 1;

  logic [SUM_W-1:0] span;

  assign span = SUM_W'(off) + SUM_W'(len);
  assign bad  = (op == 2'd3) || (olen > 2'd2) || (span > SUM_W'(65536));
endmodule

// File: rtl/i2c_reg_xfer_seq.sv
module i2c_reg_xfer_seq
  import i2cseq_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int LEN_W    = 17,
  parameter int POLL_MAX = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_off,
  input  logic [1:0]        cmd_olen,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_rstart,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              cmd_ready,
  output logic              cmd_done,
  output logic [1:0]        cmd_res,
  input  logic              ctl_busy,
  input  logic [NFLAG-1:0]  ctl_stat,
  input  logic [7:0]        ctl_rxd,
  output logic              ctl_go,
  output logic              ctl_stt,
  output logic              ctl_stp,
  output logic              ctl_trx,
  output logic [LEN_W-1:0]  ctl_cnt,
  output logic [ADDR_W-1:0] ctl_sa,
  output logic              ctl_abort,
  output logic [NFLAG-1:0]  ctl_stat_clr,
  output logic              ctl_tx_wr,
  output logic [7:0]        ctl_txd,
  output logic              ctl_rx_rd,
  output logic              buf_rd,
  input  logic [7:0]        buf_rdata,
  output logic              buf_wr,
  output logic [7:0]        buf_wdata
);
  localparam logic [NFLAG-1:0] ONLY_XRDY = NFLAG'(1) << F_XRDY;

  seq_st_e            st_q, st_n;
  logic [1:0]         op_q, op_n, res_q, res_n, offl_q, offl_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic [15:0]        off_q, off_n;
  logic [LEN_W-1:0]   len_q, len_n;
  logic               rs_q, rs_n;
  logic               bad, arm, hit, fire, tmo, evt_ok, evt_to, pads;
  logic [7:0]         off_byte;

  i2cseq_cmd_chk #(.LEN_W(LEN_W)) i_chk (
    .op(cmd_op), .olen(cmd_olen), .off(cmd_off), .len(cmd_len), .bad(bad));

  assign arm = (st_q == S_BB) || (st_q == S_ROFF) || (st_q == S_RDAT) ||
               (st_q == S_WOFF) || (st_q == S_WDAT) || (st_q == S_WEND) ||
               (st_q == S_PWAIT);
  assign hit = (st_q == S_BB) ? !ctl_busy : (|ctl_stat);

  i2cseq_waiter #(.POLL_MAX(POLL_MAX)) i_wait (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit), .fire(fire), .tmo(tmo));

  assign evt_ok   = fire && !tmo;
  assign evt_to   = fire && tmo;
  assign pads     = (ctl_stat == ONLY_XRDY) && !ctl_busy;
  assign off_byte = (offl_q == 2'd2) ? off_q[15:8] : off_q[7:0];

  assign cmd_ready = (st_q == S_IDLE);
  assign cmd_res   = res_q;
  assign ctl_sa    = addr_q;
  assign buf_wdata = ctl_rxd;
  assign ctl_txd   = (st_q == S_WDAT) ? buf_rdata : off_byte;

  always_comb begin
    st_n = st_q;  op_n = op_q;  res_n = res_q;  offl_n = offl_q;
    addr_n = addr_q;  off_n = off_q;  len_n = len_q;  rs_n = rs_q;
    ctl_go = 1'b0;  ctl_stt = 1'b0;  ctl_stp = 1'b0;  ctl_trx = 1'b0;
    ctl_cnt = '0;  ctl_abort = 1'b0;  ctl_stat_clr = '0;
    ctl_tx_wr = 1'b0;  ctl_rx_rd = 1'b0;  buf_rd = 1'b0;  buf_wr = 1'b0;
    cmd_done = 1'b0;
    case (st_q)
      S_IDLE: if (cmd_valid) begin
        op_n = cmd_op;  addr_n = cmd_addr;  off_n = cmd_off;
        offl_n = cmd_olen;  len_n = cmd_len;  rs_n = cmd_rstart;
        if (bad || (cmd_op == OP_PRB && cmd_addr == own_addr)) begin
          res_n = RES_ERR;  st_n = S_FAST;
        end else begin
          st_n = S_BB;
        end
      end
      S_FAST: begin cmd_done = 1'b1;  st_n = S_IDLE; end
      S_BB: if (evt_to) begin
        res_n = RES_ERR;  st_n = S_FAST;
      end else if (evt_ok) begin
        ctl_go = 1'b1;  ctl_stt = 1'b1;
        if (op_q == OP_PRB) begin
          ctl_stp = 1'b1;  ctl_trx = 1'b1;  st_n = S_PWAIT;
        end else if (op_q == OP_WR) begin
          ctl_stp = 1'b1;  ctl_trx = 1'b1;
          ctl_cnt = LEN_W'(offl_q) + len_q;
          st_n = (offl_q != 2'd0) ? S_WOFF : ((len_q != '0) ? S_WDAT : S_WEND);
        end else if (offl_q != 2'd0) begin
          ctl_trx = 1'b1;  ctl_stp = !rs_q;  ctl_cnt = LEN_W'(offl_q);
          st_n = S_ROFF;
        end else begin
          ctl_stp = 1'b1;  ctl_cnt = len_q;  st_n = S_RDAT;
        end
      end
      S_ROFF, S_RDAT: if (evt_to) begin
        ctl_stat_clr = '1;  res_n = RES_ERR;  st_n = S_DRAIN;
      end else if (evt_ok) begin
        if (pads) begin
          res_n = RES_PADS;  st_n = S_DRAIN;
        end else if (ctl_stat[F_NACK]) begin
          res_n = RES_ERR;  st_n = S_DRAIN;
        end else begin
          ctl_stat_clr = ctl_stat & (NFLAG'(1) << F_XRDY | NFLAG'(1) << F_RRDY |
                                     NFLAG'(1) << F_ARDY);
          if (st_q == S_ROFF && ctl_stat[F_XRDY] && offl_q != 2'd0) begin
            ctl_tx_wr = 1'b1;  offl_n = offl_q - 2'd1;
          end
          if (st_q == S_RDAT && ctl_stat[F_RRDY]) begin
            ctl_rx_rd = 1'b1;  buf_wr = 1'b1;
          end
          if (ctl_stat[F_ARDY]) begin
            if (st_q == S_ROFF) begin
              ctl_go = 1'b1;  ctl_stt = 1'b1;  ctl_stp = 1'b1;
              ctl_cnt = len_q;  st_n = S_RDAT;
            end else begin
              res_n = RES_OK;  st_n = S_DRAIN;
            end
          end
        end
      end
      S_WOFF, S_WDAT: if (evt_to) begin
        ctl_stat_clr = '1;  res_n = RES_ERR;  st_n = S_DRAIN;
      end else if (evt_ok) begin
        if (st_q == S_WOFF && pads) begin
          res_n = RES_PADS;  st_n = S_DRAIN;
        end else if (ctl_stat[F_NACK] || !ctl_stat[F_XRDY]) begin
          res_n = RES_ERR;  st_n = S_DRAIN;
        end else begin
          ctl_tx_wr = 1'b1;  ctl_stat_clr[F_XRDY] = 1'b1;
          if (st_q == S_WOFF) begin
            offl_n = offl_q - 2'd1;
            if (offl_q == 2'd1) st_n = (len_q != '0) ? S_WDAT : S_WEND;
          end else begin
            buf_rd = 1'b1;  len_n = len_q - 1'b1;
            if (len_q == LEN_W'(1)) st_n = S_WEND;
          end
        end
      end
      S_WEND: if (evt_to) begin
        ctl_stat_clr = '1;  res_n = RES_ERR;  st_n = S_DRAIN;
      end else if (evt_ok) begin
        ctl_stat_clr = ctl_stat;
        if (ctl_stat[F_NACK]) begin
          res_n = RES_ERR;  st_n = S_DRAIN;
        end else if (ctl_stat[F_ARDY]) begin
          res_n = RES_OK;  st_n = S_DRAIN;
        end
      end
      S_PWAIT: if (evt_to) begin
        ctl_stat_clr = '1;  res_n = RES_ERR;  st_n = S_DRAIN;
      end else if (evt_ok) begin
        if ((ctl_stat & ~ONLY_XRDY) == '0 || ctl_stat[F_AL] || ctl_stat[F_NACK]) begin
          res_n = RES_ERR;  st_n = S_DRAIN;
        end else begin
          res_n = RES_OK;  st_n = S_ABT;
        end
      end
      S_ABT:  begin ctl_abort = 1'b1;  st_n = S_STOP; end
      S_STOP: begin
        ctl_go = 1'b1;  ctl_stp = 1'b1;  ctl_trx = 1'b1;  st_n = S_DRAIN;
      end
      S_DRAIN: if (ctl_stat[F_RRDY]) begin
        ctl_rx_rd = 1'b1;  ctl_stat_clr[F_RRDY] = 1'b1;
      end else begin
        st_n = S_FIN;
      end
      S_FIN: begin ctl_stat_clr = '1;  cmd_done = 1'b1;  st_n = S_IDLE; end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  op_q <= '0;  res_q <= '0;  offl_q <= '0;
      addr_q <= '0;  off_q <= '0;  len_q <= '0;  rs_q <= 1'b0;
    end else begin
      st_q <= st_n;  op_q <= op_n;  res_q <= res_n;  offl_q <= offl_n;
      addr_q <= addr_n;  off_q <= off_n;  len_q <= len_n;  rs_q <= rs_n;
    end
  end

  // R3: a byte is pushed only on transmit ready, and that flag is acknowledged with it
  p_tx_on_xrdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_tx_wr |-> (ctl_stat[F_XRDY] && ctl_stat_clr[F_XRDY]));
  // R5: a byte is popped only on receive ready
  p_rx_on_rrdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rx_rd |-> ctl_stat[F_RRDY]);
  // R1: an illegal command finishes on the following cycle with error
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid && bad) |=> (cmd_done && cmd_res == RES_ERR && !ctl_go));
  // R9: a forced idle is followed by a stop-only launch
  p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_abort |=> (ctl_go && ctl_stp && !ctl_stt));
  // R10: the end pulse is never raised while a transfer is being launched
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (!ctl_go && !ctl_tx_wr && !ctl_rx_rd));
endmodule

// File: tb/test_i2c_reg_xfer_seq.sv
module test_i2c_reg_xfer_seq;
  localparam int SC_OK = 0, SC_NACK = 1, SC_PADS = 2, SC_HANG = 3, SC_NRX = 4;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_rstart = 1'b0;
  logic [1:0] cmd_op = '0, cmd_olen = '0;
  logic [6:0] cmd_addr = '0;
  logic [15:0] cmd_off = '0;
  logic [16:0] cmd_len = '0;
  logic cmd_ready, cmd_done, ctl_go, ctl_stt, ctl_stp, ctl_trx, ctl_abort;
  logic ctl_tx_wr, ctl_rx_rd, buf_rd, buf_wr, ctl_busy;
  logic [1:0] cmd_res;
  logic [16:0] ctl_cnt;
  logic [6:0] ctl_sa, ctl_stat_clr;
  logic [7:0] ctl_txd, buf_wdata, buf_rdata, rxd;
  logic [6:0] stat, s_tmp;

  // controller and buffer model
  logic mdl_rst = 1'b0, active;
  int scn = SC_OK, hold = 0, force_cnt, ph_cnt, ph_idx, dly, extra;
  logic ph_trx, ph_stp;
  int n_go, n_stop, n_abort, n_tx, n_rx, n_bw, n_br;
  int go_cnt [4]; logic go_stp [4]; logic go_trx [4];
  logic [7:0] txlog [16]; logic [7:0] rbuf [16]; logic [7:0] wdat [16];

  assign ctl_busy  = active || (force_cnt != 0);
  assign buf_rdata = wdat[n_br[3:0]];

  function automatic logic [7:0] sbyte(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || mdl_rst) begin
      stat <= '0; active <= 1'b0; force_cnt <= hold; dly <= 0; extra <= 0;
      ph_cnt <= 0; ph_idx <= 0; ph_trx <= 1'b0; ph_stp <= 1'b0; rxd <= '0;
      n_go <= 0; n_stop <= 0; n_abort <= 0; n_tx <= 0; n_rx <= 0; n_bw <= 0; n_br <= 0;
    end else begin
      s_tmp = stat & ~ctl_stat_clr;
      if (force_cnt != 0) force_cnt <= force_cnt - 1;
      if (dly != 0) dly <= dly - 1;
      if (ctl_go) begin
        if (n_go < 4) begin
          go_cnt[n_go] <= int'(ctl_cnt); go_stp[n_go] <= ctl_stp; go_trx[n_go] <= ctl_trx;
        end
        n_go <= n_go + 1;
        if (ctl_stt) begin
          active <= 1'b1; ph_cnt <= int'(ctl_cnt); ph_trx <= ctl_trx;
          ph_stp <= ctl_stp; dly <= 3; ph_idx <= 0;
        end else begin
          n_stop <= n_stop + 1; active <= 1'b0;
        end
      end
      if (ctl_abort) n_abort <= n_abort + 1;
      if (ctl_tx_wr) begin
        txlog[n_tx[3:0]] <= ctl_txd; n_tx <= n_tx + 1; ph_cnt <= ph_cnt - 1; dly <= 3;
      end
      if (buf_rd) n_br <= n_br + 1;
      if (buf_wr) begin rbuf[n_bw[3:0]] <= buf_wdata; n_bw <= n_bw + 1; end
      if (ctl_rx_rd) begin
        n_rx <= n_rx + 1;
        if (extra > 0) extra <= extra - 1;
        else begin ph_cnt <= ph_cnt - 1; ph_idx <= ph_idx + 1; dly <= 3; end
      end
      if (dly == 1 && active && scn != SC_HANG) begin
        if (scn == SC_NACK) begin s_tmp[3] = 1'b1; active <= 1'b0; end
        else if (scn == SC_PADS) begin s_tmp[0] = 1'b1; active <= 1'b0; end
        else if (scn == SC_NRX && !ph_trx && ph_idx == 1) begin
          s_tmp[3] = 1'b1; s_tmp[1] = 1'b1; extra <= 1; rxd <= 8'hEE; active <= 1'b0;
        end else if (ph_cnt != 0) begin
          if (ph_trx) s_tmp[0] = 1'b1;
          else begin s_tmp[1] = 1'b1; rxd <= sbyte(ph_idx); end
        end else begin
          s_tmp[2] = 1'b1; if (ph_stp) active <= 1'b0;
        end
      end
      stat <= s_tmp;
    end
  end

  i2c_reg_xfer_seq i_i2c_reg_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_off(cmd_off), .cmd_olen(cmd_olen), .cmd_len(cmd_len),
    .cmd_rstart(cmd_rstart), .own_addr(OWN), .cmd_ready(cmd_ready),
    .cmd_done(cmd_done), .cmd_res(cmd_res), .ctl_busy(ctl_busy), .ctl_stat(stat),
    .ctl_rxd(rxd), .ctl_go(ctl_go), .ctl_stt(ctl_stt), .ctl_stp(ctl_stp),
    .ctl_trx(ctl_trx), .ctl_cnt(ctl_cnt), .ctl_sa(ctl_sa), .ctl_abort(ctl_abort),
    .ctl_stat_clr(ctl_stat_clr), .ctl_tx_wr(ctl_tx_wr), .ctl_txd(ctl_txd),
    .ctl_rx_rd(ctl_rx_rd), .buf_rd(buf_rd), .buf_rdata(buf_rdata), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata));

  int total = 0, bad = 0, res, cyc;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [6:0] a, input logic [15:0] off,
                     input logic [1:0] olen, input int len, input bit rs,
                     input int sc, input int hb);
    @(negedge clk);
    scn = sc; hold = hb; mdl_rst = 1'b1;
    cmd_op = op; cmd_addr = a; cmd_off = off; cmd_olen = olen;
    cmd_len = 17'(len); cmd_rstart = rs;
    @(negedge clk);
    mdl_rst = 1'b0; cmd_valid = 1'b1; cyc = 0;
    do begin
      @(negedge clk); cmd_valid = 1'b0; cyc++;
    end while (!cmd_done && cyc < 8000);
    res = int'(cmd_res);
    chk(cmd_done == 1'b1, "R8 command ends", cyc, 0);
    @(negedge clk);
  endtask

  function automatic logic [7:0] off_exp(input logic [15:0] off, input int olen, input int i);
    return (olen == 2 && i == 0) ? off[15:8] : off[7:0];
  endfunction

  task automatic check_rw(input bit wr, input logic [15:0] off, input int olen,
                          input int len, input bit rs);
    bit ok;
    chk(res == 0, wr ? "R6 result" : "R5 result", res, 0);
    chk(stat == '0, "R10 flags cleared", int'(stat), 0);
    if (wr) begin
      chk(n_go == 1 && go_cnt[0] == olen + len && go_stp[0] && go_trx[0],
          "R6 launch", go_cnt[0], olen + len);
      ok = (n_tx == olen + len);
      for (int i = 0; i < olen + len; i++)
        if (txlog[i] != ((i < olen) ? off_exp(off, olen, i) : wdat[i - olen])) ok = 0;
      chk(ok, "R3 R6 byte order", n_tx, olen + len);
    end else begin
      if (olen > 0)
        chk(n_go == 2 && go_cnt[0] == olen && go_trx[0] && go_stp[0] == !rs &&
            go_cnt[1] == len && go_stp[1] && !go_trx[1], "R4 two launches", n_go, 2);
      else
        chk(n_go == 1 && go_cnt[0] == len && go_stp[0] && !go_trx[0],
            "R4 single launch", n_go, 1);
      ok = (n_tx == olen);
      for (int i = 0; i < olen; i++) if (txlog[i] != off_exp(off, olen, i)) ok = 0;
      chk(ok, "R3 offset bytes", n_tx, olen);
      ok = (n_bw == len);
      for (int i = 0; i < len; i++) if (rbuf[i] != sbyte(i)) ok = 0;
      chk(ok, "R5 read data", n_bw, len);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 16; i++) wdat[i] = 8'(8'h51 + i * 13);
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && cmd_done == 1'b0, "R1 reset idle", int'(cmd_ready), 1);
    rst_n = 1'b1;

    // R1 rejections
    run(2'd0, 7'h50, 16'h0000, 2'd3, 1, 1'b1, SC_OK, 0);
    chk(res == 1 && cyc == 1 && n_go == 0, "R1 olen 3", res, 1);
    run(2'd1, 7'h50, 16'hFFFF, 2'd2, 2, 1'b1, SC_OK, 0);
    chk(res == 1 && cyc == 1 && n_go == 0, "R1 range", res, 1);
    run(2'd3, 7'h50, 16'h0000, 2'd0, 0, 1'b1, SC_OK, 0);
    chk(res == 1 && cyc == 1 && n_go == 0, "R1 opcode 3", res, 1);
    run(2'd1, 7'h50, 16'hFFFE, 2'd2, 2, 1'b1, SC_OK, 0);
    check_rw(1'b1, 16'hFFFE, 2, 2, 1'b1);

    // R2 busy
    run(2'd0, 7'h50, 16'h0012, 2'd1, 2, 1'b0, SC_OK, 30);
    chk(cyc > 30, "R2 waits for idle bus", cyc, 31);
    check_rw(1'b0, 16'h0012, 1, 2, 1'b0);
    run(2'd0, 7'h50, 16'h0012, 2'd1, 2, 1'b0, SC_OK, 100000);
    chk(res == 1 && n_go == 0 && cyc >= 1000, "R2 busy timeout", res, 1);

    // R4 both start modes, R5 reads
    run(2'd0, 7'h51, 16'hA55A, 2'd2, 3, 1'b1, SC_OK, 0);
    check_rw(1'b0, 16'hA55A, 2, 3, 1'b1);
    run(2'd0, 7'h51, 16'hA55A, 2'd2, 3, 1'b0, SC_OK, 0);
    check_rw(1'b0, 16'hA55A, 2, 3, 1'b0);
    run(2'd0, 7'h51, 16'h0000, 2'd0, 4, 1'b0, SC_OK, 0);
    check_rw(1'b0, 16'h0000, 0, 4, 1'b0);

    // R7 unconfigured bus
    run(2'd0, 7'h52, 16'h0034, 2'd1, 2, 1'b1, SC_PADS, 0);
    chk(res == 2 && stat == '0, "R7 read offset phase", res, 2);
    run(2'd0, 7'h52, 16'h0000, 2'd0, 2, 1'b1, SC_PADS, 0);
    chk(res == 2, "R7 read data phase", res, 2);
    run(2'd1, 7'h52, 16'h0034, 2'd2, 2, 1'b1, SC_PADS, 0);
    chk(res == 2 && n_tx == 0, "R7 write offset phase", res, 2);

    // R8 nack and silence
    run(2'd1, 7'h53, 16'h0001, 2'd1, 3, 1'b1, SC_NACK, 0);
    chk(res == 1 && n_tx == 0 && stat == '0, "R8 nack", res, 1);
    run(2'd1, 7'h53, 16'h0001, 2'd1, 3, 1'b1, SC_HANG, 0);
    chk(res == 1 && cyc >= 1000 && stat == '0, "R8 poll timeout", res, 1);

    // R10 drain after mid-read nack
    run(2'd0, 7'h54, 16'h0000, 2'd0, 4, 1'b1, SC_NRX, 0);
    chk(res == 1 && n_bw == 1 && n_rx == 2 && stat == '0, "R10 drain", n_rx, 2);

    // R9 probes
    run(2'd2, OWN, 16'h0000, 2'd0, 0, 1'b1, SC_OK, 0);
    chk(res == 1 && n_go == 0 && cyc == 1, "R9 own address", res, 1);
    run(2'd2, 7'h55, 16'h0000, 2'd0, 0, 1'b1, SC_OK, 0);
    chk(res == 0 && n_go == 2 && go_cnt[0] == 0 && go_stp[0] && go_trx[0] &&
        n_abort == 1 && n_stop == 1, "R9 slave present", res, 0);
    run(2'd2, 7'h56, 16'h0000, 2'd0, 0, 1'b1, SC_NACK, 0);
    chk(res == 1 && n_abort == 0 && n_stop == 0, "R9 slave absent", res, 1);
    run(2'd2, 7'h56, 16'h0000, 2'd0, 0, 1'b1, SC_PADS, 0);
    chk(res == 1 && n_abort == 0, "R9 lone transmit ready", res, 1);

    // random reads and writes
    for (int k = 0; k < 40; k++) begin
      logic [1:0] ol; int ln; logic [15:0] of; bit w, r;
      ol = 2'($urandom_range(0, 2)); ln = $urandom_range(0, 6);
      of = 16'($urandom_range(0, 60000)); w = 1'($urandom_range(0, 1));
      r = 1'($urandom_range(0, 1));
      for (int i = 0; i < 16; i++) wdat[i] = 8'($urandom_range(0, 255));
      run(w ? 2'd1 : 2'd0, 7'h60, of, ol, ln, r, SC_OK, 0);
      check_rw(w, of, int'(ol), ln, r);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule